// File: doc/BRIEF.md
# Receive Bit-Clock Recovery with Flywheel Sync

This block sits behind the receive demodulator of a low-rate tone modem. It takes the hard-limited, not-yet-retimed received data bit, recovers a bit clock from the transitions in that stream, and delivers two outputs. The first is a square-wave sync that free-runs at the nominal bit rate and is nudged toward the incoming bit timing whenever a data edge arrives. The second is the received data re-timed onto that sync.

The nominal bit period comes from dividing the master clock down to the selected baud rate. The rate is chosen by three static select inputs: a master-clock speed flag plus two rate pins, using the same encoding as the transmit path. The incoming data goes through a two-flop synchroniser. Each detected edge pulls the bit-phase counter toward its ideal position by a rounded eighth of the phase error. Through long runs without transitions, the sync keeps running at the nominal rate. Pulling the receive-enable input low puts the block in powersave, where both outputs are held low.

Top module: `rxclk_recovery`

## Requirements
- R1: During and straight after reset, `syncOut` and `clockedData` are 0.
- R2: The bit period in master-clock cycles depends on the inputs, with B = `BASE_DIV` (840 by default). With `fastClk`=0, `sel1200`=1 gives B and `sel1200`=0 gives B/2. With `fastClk`=1, `sel1200`=1 gives 4B, `sel1200`=0 with `sel4800`=1 gives B, and `sel1200`=0 with `sel4800`=0 gives 2B.
- R3: When there are no data transitions, `syncOut` free-runs with exactly that period. It is high for P − P/2 cycles of each period.
- R4: `clockedData` changes only in the cycle where `syncOut` rises, or when powersave forces it low.
- R5: `clockedData` holds the value of `rxDataIn` sampled at mid-bit. Once the loop is locked, every bit of an arbitrary pattern, including long runs of equal bits, comes out once per sync period and in order.
- R6: On each synchronised data edge, the phase counter moves toward the bit boundary by (|error| + 4) / 8 cycles. After 32 alternating bits, each `syncOut` rise falls P/2 + 2 cycles after the input edge (two cycles of synchroniser delay), within ±4 cycles.
- R7: While `rxEnable` is 0, `syncOut` and `clockedData` are held at 0 whatever `rxDataIn` does. After `rxEnable` returns to 1 with the data stable, the first `syncOut` rise comes P/2 cycles later.
- R8: Selecting 4800 baud while `fastClk` is 0 is not a valid rate, and the block falls back to the 2400-baud period B/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | 1 = receive active, 0 = powersave |
| fastClk | input | 1 | Master clock speed: 1 = fast (×4), 0 = slow |
| sel1200 | input | 1 | 1 = lowest baud rate |
| sel4800 | input | 1 | With sel1200 = 0 and fastClk = 1, selects the highest rate |
| rxDataIn | input | 1 | Unclocked received data bit |
| syncOut | output | 1 | Recovered flywheel bit clock; rises at the mid-bit latch instant |
| clockedData | output | 1 | Received data re-timed on the recovered clock |

## Verification
The bench targets several boundaries of the loop:

- **Phase correction.** It measures the lock position after an alternating preamble that starts from an arbitrary phase. A loop whose correction has the wrong sign, or is missing, leaves the sync rise far from mid-bit and fails the lock window.
- **Flywheel behaviour.** It sends runs of twelve equal bits. A counter that drifts or resets without edges then drops or duplicates bits in the scoreboard.
- **Rate decode.** It measures the free-running period and the high time for every select combination, including the invalid 4800-on-slow-clock case, so a wrong decode or divider shows up as a wrong period.
- **Powersave.** It toggles the data during powersave and times the first rise after re-enable. Outputs that leak, or a counter that is not held, are caught there.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  typedef enum logic [1:0] {
    RATE_LOW  = 2'd0,
    RATE_MID  = 2'd1,
    RATE_HIGH = 2'd2
  } rate_e;

  // Strobes from the phase control to the datapath
  typedef struct packed {
    logic sampleNow;  // latch data this edge
    logic syncLevel;  // next level of the sync square wave
    logic sleep;      // powersave: force outputs low
  } rcr_strobe_t;

  // Rate decode; the top rate needs the fast master clock, else mid rate
  function automatic rate_e decodeRate(input logic fastClk,
                                       input logic sel1200,
                                       input logic sel4800);
    if (sel1200)                 return RATE_LOW;
    else if (sel4800 && fastClk) return RATE_HIGH;
    else                         return RATE_MID;
  endfunction

endpackage

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter int BASE_DIV = 840
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        fastClk,
  input  logic        sel1200,
  input  logic        sel4800,
  input  logic        edgeSeen,
  output rcr_strobe_t strb
);
  localparam int PMAX = 4 * BASE_DIV;
  localparam int CW   = $clog2(PMAX + 1);
  localparam logic [CW-1:0] P_QUART = CW'(BASE_DIV / 2);
  localparam logic [CW-1:0] P_ONE   = CW'(BASE_DIV);
  localparam logic [CW-1:0] P_TWO   = CW'(2 * BASE_DIV);
  localparam logic [CW-1:0] P_FOUR  = CW'(4 * BASE_DIV);

  rate_e         rate;
  logic [CW-1:0] period;
  logic [CW-1:0] half;
  logic [CW-1:0] ph;
  logic [CW-1:0] phNext;
  logic [CW-1:0] errMag;
  logic [CW-1:0] corr;
  logic [CW:0]   wide;

  // Nominal bit period
  always_comb begin
    rate = decodeRate(fastClk, sel1200, sel4800);
    unique case (rate)
      RATE_LOW:  period = fastClk ? P_FOUR : P_ONE;
      RATE_HIGH: period = P_ONE;
      default:   period = fastClk ? P_TWO : P_QUART;
    endcase
    half = period >> 1;
  end

  // Phase counter next state with edge-driven correction
  always_comb begin
    errMag = '0;
    corr   = '0;
    wide   = '0;
    phNext = '0;
    if (!rxEnable) begin
      phNext = '0;
    end else if (edgeSeen) begin
      if (ph >= period) begin
        phNext = '0;
      end else if (ph < half) begin
        // counter ahead of the edge: slow down
        errMag = ph;
        corr   = (errMag + CW'(4)) >> 3;
        phNext = ph + CW'(1) - corr;
      end else begin
        // counter behind the edge: speed up
        errMag = period - ph;
        corr   = (errMag + CW'(4)) >> 3;
        wide   = {1'b0, ph} + {{CW{1'b0}}, 1'b1} + {1'b0, corr};
        if (wide >= {1'b0, period}) wide = wide - {1'b0, period};
        phNext = wide[CW-1:0];
      end
    end else begin
      phNext = (ph >= period - CW'(1)) ? '0 : ph + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ph <= '0;
    else       ph <= phNext;
  end

  // Mid-bit is entered only through the exact value 'half'
  always_comb begin
    strb.sleep     = !rxEnable;
    strb.sampleNow = rxEnable && (phNext == half) && (ph != half);
    strb.syncLevel = rxEnable && (phNext >= half);
  end

endmodule

// File: rtl/rcr_datapath.sv
module rcr_datapath
  import rcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxDataIn,
  input  rcr_strobe_t strb,
  output logic        edgeSeen,
  output logic        syncOut,
  output logic        clockedData
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   dataPrev;
  logic                   dataSync;

  // Synchroniser runs through powersave so re-enable sees no false edge
  generate
    genvar gi;
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        syncChain[gi] <= 1'b0;
        else if (gi == 0) syncChain[gi] <= rxDataIn;
        else              syncChain[gi] <= syncChain[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign dataSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataPrev <= 1'b0;
    else       dataPrev <= dataSync;
  end

  assign edgeSeen = dataSync ^ dataPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncOut     <= 1'b0;
      clockedData <= 1'b0;
    end else begin
      syncOut <= strb.syncLevel;
      if (strb.sleep)          clockedData <= 1'b0;
      else if (strb.sampleNow) clockedData <= dataSync;
    end
  end

endmodule

// File: rtl/rxclk_recovery.sv
module rxclk_recovery
  import rcr_pkg::*;
#(
  parameter int BASE_DIV = 840
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxEnable,
  input  logic fastClk,
  input  logic sel1200,
  input  logic sel4800,
  input  logic rxDataIn,
  output logic syncOut,
  output logic clockedData
);
  rcr_strobe_t strb;
  logic        edgeSeen;

  rcr_ctrl #(.BASE_DIV(BASE_DIV)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .fastClk  (fastClk),
    .sel1200  (sel1200),
    .sel4800  (sel4800),
    .edgeSeen (edgeSeen),
    .strb     (strb)
  );

  rcr_datapath #(.SYNC_STAGES(2)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxDataIn    (rxDataIn),
    .strb        (strb),
    .edgeSeen    (edgeSeen),
    .syncOut     (syncOut),
    .clockedData (clockedData)
  );

endmodule

// File: rtl/rxclk_recovery_chk.sv
module rxclk_recovery_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic fastClk,
  input logic sel1200,
  input logic sel4800,
  input logic rxDataIn,
  input logic syncOut,
  input logic clockedData
);
  AST_SLEEP_DATA_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !clockedData); // R7

  AST_SLEEP_SYNC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !syncOut); // R7

  AST_DATA_AT_SYNC_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxEnable) && !$stable(clockedData)) |-> $rose(syncOut)); // R4

  AST_SYNC_NO_GLITCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncOut) && rxEnable) |=> syncOut); // R3

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> $past(rxEnable)); // R7

endmodule

bind rxclk_recovery rxclk_recovery_chk chk_i (.*);

// File: tb/rxclk_recovery_tb_top.sv
`timescale 1ns/1ps
module rxclk_recovery_tb_top;
  localparam int BASE = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0;
  logic fastClk = 1'b0;
  logic sel1200 = 1'b1;
  logic sel4800 = 1'b0;
  logic rxData = 1'b0;
  logic syncOut;
  logic clockedData;

  always #2.5 clk = ~clk;

  rxclk_recovery #(.BASE_DIV(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fastClk(fastClk),
    .sel1200(sel1200), .sel4800(sel4800), .rxDataIn(rxData),
    .syncOut(syncOut), .clockedData(clockedData)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  vectors = 0;
  int  errors = 0;
  bit  expQ[$];
  bit  scoring = 0;
  bit  lockCheck = 0;
  int  lastChange = 0;
  int  halfNow = BASE / 2;
  logic prevSync = 1'b0;
  logic prevData = 1'b0;
  logic enAtEdge = 1'b0;
  bit  done = 0;

  always @(posedge clk) enAtEdge <= rxEnable;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expPeriod(input bit f, input bit s12, input bit s48);
    if (f) return s12 ? 4*BASE : (s48 ? BASE : 2*BASE);
    else   return s12 ? BASE : BASE/2;
  endfunction

  // Monitor: scoreboard pops, lock window, data-change timing
  always @(negedge clk) begin
    if (rstN) begin
      if (syncOut && !prevSync) begin
        if (scoring && expQ.size() > 0) begin
          bit e;
          e = expQ.pop_front();
          check(clockedData == e, "R5", int'(clockedData), int'(e));
        end
        if (lockCheck) begin
          int d;
          d = cyc - lastChange;
          check((d >= halfNow + 2 - 4) && (d <= halfNow + 2 + 4), "R6", d, halfNow + 2);
        end
      end
      if (clockedData != prevData && enAtEdge)
        check(syncOut && !prevSync, "R4", int'(syncOut), 1);
    end
    prevSync = syncOut;
    prevData = clockedData;
  end

  task automatic driveBit(input bit b, input bit push, input int p);
    @(negedge clk);
    if (b != rxData) lastChange = cyc;
    rxData = b;
    if (push) expQ.push_back(b);
    repeat (p - 1) @(negedge clk);
  endtask

  task automatic setRate(input bit f, input bit s12, input bit s48);
    @(negedge clk);
    fastClk = f; sel1200 = s12; sel4800 = s48;
  endtask

  task automatic measure(input bit f, input bit s12, input bit s48, input string req);
    int p, t0, t1, t2;
    setRate(f, s12, s48);
    p = expPeriod(f, s12, s48);
    repeat (3 * p) @(negedge clk);
    while (syncOut)  @(negedge clk);
    while (!syncOut) @(negedge clk);
    t0 = cyc;
    while (syncOut)  @(negedge clk);
    t1 = cyc;
    while (!syncOut) @(negedge clk);
    t2 = cyc;
    check(t2 - t0 == p, req, t2 - t0, p);
    check(t1 - t0 == p - p/2, "R3", t1 - t0, p - p/2);
  endtask

  task automatic runStream(input bit f, input bit s12, input bit s48, input bit doLock);
    int p;
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    setRate(f, s12, s48);
    p = expPeriod(f, s12, s48);
    halfNow = p / 2;
    for (int i = 0; i < 32; i++) begin
      lockCheck = doLock && (i >= 26);
      driveBit(~rxData, 0, p);
    end
    lockCheck = 0;
    scoring = 1;
    for (int i = 0; i < 44; i++) begin
      bit b;
      if (i >= 10 && i < 22)      b = 1'b1;   // long run of ones
      else if (i >= 22 && i < 34) b = 1'b0;   // long run of zeros
      else begin
        b = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[4], lfsr[7:1]};
      end
      driveBit(b, 1, p);
    end
    repeat (2 * p) @(negedge clk);
    scoring = 0;
    check(expQ.size() == 0, "R5", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    check(syncOut == 1'b0, "R1", int'(syncOut), 0);
    check(clockedData == 1'b0, "R1", int'(clockedData), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(syncOut == 1'b0, "R1", int'(syncOut), 0);
    check(clockedData == 1'b0, "R1", int'(clockedData), 0);

    // R7: re-enable timing from held phase
    @(negedge clk);
    c = cyc;
    rxEnable = 1'b1;
    while (!syncOut) @(negedge clk);
    check(cyc - c == BASE/2, "R7", cyc - c, BASE/2);

    // R2, R3, R8: free-running periods for all select combinations
    measure(0, 1, 0, "R2");
    measure(0, 0, 0, "R2");
    measure(0, 0, 1, "R8");
    measure(1, 1, 0, "R2");
    measure(1, 0, 0, "R2");
    measure(1, 0, 1, "R2");

    // R5, R6: locking and scoreboarded data at several rates
    runStream(0, 1, 0, 1);
    runStream(0, 0, 0, 0);
    runStream(1, 0, 0, 0);
    runStream(1, 0, 1, 1);

    // R7: powersave with toggling data
    setRate(0, 1, 0);
    @(negedge clk);
    rxEnable = 1'b0;
    for (int k = 0; k < 6; k++) begin
      repeat (23) @(negedge clk);
      rxData = ~rxData;
      @(negedge clk);
      check(syncOut == 1'b0, "R7", int'(syncOut), 0);
      check(clockedData == 1'b0, "R7", int'(clockedData), 0);
    end
    repeat (6) @(negedge clk);
    c = cyc;
    rxEnable = 1'b1;
    while (!syncOut) @(negedge clk);
    check(cyc - c == BASE/2, "R7", cyc - c, BASE/2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule